// File: doc/BRIEF.md
# Audio Control Register Decoder

This block sits behind a two-wire serial receiver in an audio processor and turns each received command byte into settings for the analog path. Every byte carries its own destination in its leading bits, so no register address or multi-byte framing is needed. A single-cycle strobe marks the byte as valid. The block picks one of six settings registers from the prefix and loads the rest of the byte into that register. The six registers are master volume, left speaker attenuation, right speaker attenuation, source switch, bass and treble.

The outputs are plain step counts that the analog side uses directly:

- **Volume:** attenuation in 1.25 dB units.
- **Speakers:** attenuation in 1.25 dB units for each side, plus a mute flag for each side.
- **Source switch:** a 2-bit stereo source select and two general-purpose digital pins.
- **Tone:** bass and treble levels as signed counts of 2 dB.

A synchronous active-low reset loads a defined quiet power-up state.

Top module: `audio_ctl_decoder`

## Requirements
- R1: A strobed byte `00bbbaaa` sets `vol_att` to the 6-bit value `byte_dat[5:0]`. This equals bbb·8 + aaa steps of 1.25 dB (0 to 63), so 0x24 gives 36, which is −45 dB.
- R2: A strobed byte `100bbaaa` sets `spk_l_att`, and `101bbaaa` sets `spk_r_att`, to bb·8 + aaa (the 5-bit field `byte_dat[4:0]`). The other side is left unchanged, so 0xB4 gives right attenuation 20, which is −25 dB.
- R3: A speaker field of 11111 sets that side's mute flag, and its attenuation reads 31. Any other speaker field clears that side's mute flag.
- R4: A strobed byte `010 d2 d1 s2 s1 s0` drives `dig_out[1]` from d2 (bit 4) and `dig_out[0]` from d1 (bit 3). When s2 (bit 2) is 1, `in_sel` takes s1s0 (00 = stereo source 1 through 11 = source 4).
- R5: A source-switch byte with s2 = 0 updates `dig_out` but leaves `in_sel` unchanged.
- R6: A strobed byte `0110cccc` sets `bass_lvl`, and `0111cccc` sets `treble_lvl`, as a 4-bit two's-complement count of 2 dB steps. Codes c below 8 give c − 7, and codes 8 and above give 15 − c, so both 0111 and 1111 give 0 and 0x62 gives −5 (−10 dB).
- R7: Strobed bytes whose top two bits are 11 change no output.
- R8: Only the register addressed by a strobed byte changes. With `byte_vld` low, every output holds its value whatever `byte_dat` carries.
- R9: While `rst_n` is low at a clock edge, the outputs load these values:
  - `vol_att` = 63
  - `bass_lvl` = `treble_lvl` = +1
  - both speakers muted with attenuation 31
  - `in_sel` = 00
  - `dig_out` = 11

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe qualifying `byte_dat` |
| byte_dat | input | 8 | Received command byte |
| vol_att | output | 6 | Volume attenuation, 1.25 dB units |
| spk_l_att | output | 5 | Left speaker attenuation, 1.25 dB units |
| spk_l_mute | output | 1 | Left speaker muted |
| spk_r_att | output | 5 | Right speaker attenuation, 1.25 dB units |
| spk_r_mute | output | 1 | Right speaker muted |
| in_sel | output | 2 | Stereo source select (0 = source 1) |
| dig_out | output | 2 | General-purpose digital pins (bit 0 = pin 1) |
| bass_lvl | output | 4 | Signed bass level, 2 dB units |
| treble_lvl | output | 4 | Signed treble level, 2 dB units |

## Verification
The assertions check a set of rules on every cycle:

- Each register holds its value when it is not addressed.
- The volume loads the byte's low field.
- The mute flag follows the all-ones speaker code.
- A source byte with s2 clear keeps `in_sel`.
- Both zero tone codes decode to 0, and a tone level never reaches −8.
- A reserved prefix selects no register.
- Reset loads the power-up values.

The bench's scenarios show the things that need a whole sequence of bytes. These are the worked examples (−45 dB, −25 dB, −10 dB bass), the full 16-code tone table for both tone registers, and isolation between neighbouring registers over long mixed streams. They also show that a reserved byte or an unstrobed byte leaves every output as it was.

// File: rtl/acd_pkg.sv
// Shared widths and command identifiers for the audio control decoder.
// Assumes one command per byte, identified by its leading bits.
package acd_pkg;
    localparam int BYTE_W = 8;
    localparam int VOL_W  = 6;
    localparam int SPK_W  = 5;
    localparam int TONE_W = 4;
    localparam int SEL_W  = 2;
    localparam int DOUT_N = 2;
    localparam int SIDES  = 2;
    localparam int PFX_W  = 4;

    typedef enum logic [2:0] {
        CMD_VOL    = 3'd0,
        CMD_SPK_L  = 3'd1,
        CMD_SPK_R  = 3'd2,
        CMD_SWITCH = 3'd3,
        CMD_BASS   = 3'd4,
        CMD_TREBLE = 3'd5
    } cmd_e;

    localparam int NCMD = 6;

    localparam logic [VOL_W-1:0]  VOL_RST  = '1;
    localparam logic [SPK_W-1:0]  SPK_MUTE = '1;
    localparam logic [TONE_W-1:0] TONE_RST = 4'sd1;
    localparam logic [SEL_W-1:0]  SEL_RST  = '0;
    localparam logic [DOUT_N-1:0] DOUT_RST = '1;
endpackage

// File: rtl/acd_cmd_classify.sv
// Command classifier: maps the top nibble of a strobed byte to a one-hot
// register select. Assumes the byte is valid only while byte_vld is high;
// prefix 11 is reserved and selects nothing.
module acd_cmd_classify
    import acd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_vld,
    input  logic [PFX_W-1:0]    byte_hi,
    output logic [NCMD-1:0]     hit
);
    // Decode the prefix into a one-hot register select.
    always_comb begin
        hit = '0;
        if (byte_vld) begin
            casez (byte_hi)
                4'b00??: hit[CMD_VOL]    = 1'b1;
                4'b100?: hit[CMD_SPK_L]  = 1'b1;
                4'b101?: hit[CMD_SPK_R]  = 1'b1;
                4'b010?: hit[CMD_SWITCH] = 1'b1;
                4'b0110: hit[CMD_BASS]   = 1'b1;
                4'b0111: hit[CMD_TREBLE] = 1'b1;
                default: hit = '0;
            endcase
        end
    end

    // R7: reserved prefix addresses no register.
    p_reserved_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_hi[3:2] == 2'b11) |-> (hit == '0));

    // R8: no strobe, no register select.
    p_idle_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |-> (hit == '0));
endmodule

// File: rtl/acd_spk_reg.sv
// One speaker attenuator register. Holds a 5-bit step count; the all-ones
// code is the mute code. Assumes load is a single-cycle select.
module acd_spk_reg
    import acd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SPK_W-1:0] code,
    output logic [SPK_W-1:0] att,
    output logic             mute
);
    // Load the step count and mute flag, or power up muted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            att  <= SPK_MUTE;
            mute <= 1'b1;
        end else if (load) begin
            att  <= code;
            mute <= (code == SPK_MUTE);
        end
    end

    // R3: the all-ones field mutes.
    p_mute_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code == SPK_MUTE) |=> mute);
    // R3: any other field unmutes.
    p_unmute_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code != SPK_MUTE) |=> !mute);
    // R8: unaddressed register holds.
    p_spk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(att) && $stable(mute)));
    // R9: reset mutes.
    p_spk_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (mute && att == SPK_MUTE));
endmodule

// File: rtl/acd_tone_reg.sv
// One tone register. Converts the sign-plus-inverted-magnitude code to a
// signed count of 2 dB steps; codes 0111 and 1111 both give zero.
// Assumes load is a single-cycle select.
module acd_tone_reg
    import acd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TONE_W-1:0] code,
    output logic [TONE_W-1:0] lvl
);
    logic [TONE_W-1:0] dec;

    // Cut codes count up towards zero, boost codes count down from +7.
    always_comb begin
        if (code[TONE_W-1]) dec = ~code;
        else                dec = code - 4'd7;
    end

    // Load the decoded level, or the power-up boost of one step.
    always_ff @(posedge clk) begin
        if (!rst_n)    lvl <= TONE_RST;
        else if (load) lvl <= dec;
    end

    // R6: both zero codes give zero.
    p_tone_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && code[2:0] == 3'b111) |=> (lvl == '0));
    // R6: the level stays within -7..+7.
    p_tone_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lvl != 4'b1000);
    // R8: unaddressed register holds.
    p_tone_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(lvl));
    // R9: reset value is +1.
    p_tone_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (lvl == TONE_RST));
endmodule

// File: rtl/audio_ctl_decoder.sv
// Audio control register decoder, top level. Classifies each strobed byte by
// its prefix and loads volume, two speaker attenuators, the source switch and
// two tone registers. Assumes byte_vld pulses one cycle per received byte.
module audio_ctl_decoder
    import acd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [7:0]        byte_dat,
    output logic [5:0]        vol_att,
    output logic [4:0]        spk_l_att,
    output logic              spk_l_mute,
    output logic [4:0]        spk_r_att,
    output logic              spk_r_mute,
    output logic [1:0]        in_sel,
    output logic [1:0]        dig_out,
    output logic [3:0]        bass_lvl,
    output logic [3:0]        treble_lvl
);
    logic [NCMD-1:0]   hit;
    logic [SPK_W-1:0]  spk_att_a  [SIDES];
    logic              spk_mute_a [SIDES];
    logic [TONE_W-1:0] tone_a     [SIDES];

    acd_cmd_classify u_cls (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_vld (byte_vld),
        .byte_hi  (byte_dat[BYTE_W-1 -: PFX_W]),
        .hit      (hit)
    );

    // Left then right speaker attenuators.
    for (genvar g = 0; g < SIDES; g++) begin : g_spk
        acd_spk_reg u_spk (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (hit[int'(CMD_SPK_L) + g]),
            .code  (byte_dat[SPK_W-1:0]),
            .att   (spk_att_a[g]),
            .mute  (spk_mute_a[g])
        );
    end

    // Bass then treble tone registers.
    for (genvar g = 0; g < SIDES; g++) begin : g_tone
        acd_tone_reg u_tone (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (hit[int'(CMD_BASS) + g]),
            .code  (byte_dat[TONE_W-1:0]),
            .lvl   (tone_a[g])
        );
    end

    assign spk_l_att  = spk_att_a[0];
    assign spk_l_mute = spk_mute_a[0];
    assign spk_r_att  = spk_att_a[1];
    assign spk_r_mute = spk_mute_a[1];
    assign bass_lvl   = tone_a[0];
    assign treble_lvl = tone_a[1];

    // Volume register: the low six bits are coarse*8 + fine directly.
    always_ff @(posedge clk) begin
        if (!rst_n)              vol_att <= VOL_RST;
        else if (hit[CMD_VOL])   vol_att <= byte_dat[VOL_W-1:0];
    end

    // Source switch: pins always load, source only when the enable bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sel  <= SEL_RST;
            dig_out <= DOUT_RST;
        end else if (hit[CMD_SWITCH]) begin
            dig_out <= byte_dat[4:3];
            if (byte_dat[2]) in_sel <= byte_dat[SEL_W-1:0];
        end
    end

    // R1: volume byte loads its low field.
    p_vol_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_dat[7:6] == 2'b00) |=> (vol_att == $past(byte_dat[5:0])));
    // R4: pins follow d2/d1 of a switch byte.
    p_pins_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_dat[7:5] == 3'b010) |=> (dig_out == $past(byte_dat[4:3])));
    // R5: source kept when the enable bit is clear.
    p_sel_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_dat[7:5] == 3'b010 && !byte_dat[2]) |=> $stable(in_sel));
    // R8: non-volume bytes leave volume alone.
    p_vol_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && byte_dat[7:6] == 2'b00) |=> $stable(vol_att));
    // R9: reset values of volume, source and pins.
    p_top_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (vol_att == VOL_RST && in_sel == SEL_RST && dig_out == DOUT_RST));
endmodule

// File: tb/audio_ctl_decoder_test.sv
`timescale 1ns/1ps
module audio_ctl_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_dat = 8'h00;
    logic [5:0] vol_att;
    logic [4:0] spk_l_att, spk_r_att;
    logic       spk_l_mute, spk_r_mute;
    logic [1:0] in_sel, dig_out;
    logic [3:0] bass_lvl, treble_lvl;

    int n_chk = 0;
    int n_fail = 0;
    bit armed = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_vol, m_sel, m_dout;
    int m_att[2];
    int m_mute[2];
    int m_tone[2];

    always #4 clk = ~clk;

    audio_ctl_decoder uut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .vol_att(vol_att), .spk_l_att(spk_l_att), .spk_l_mute(spk_l_mute),
        .spk_r_att(spk_r_att), .spk_r_mute(spk_r_mute), .in_sel(in_sel),
        .dig_out(dig_out), .bass_lvl(bass_lvl), .treble_lvl(treble_lvl)
    );

    function automatic int tone_of(int c);
        return (c < 8) ? c - 7 : 15 - c;
    endfunction

    // behavioural model, updated at each rising edge
    always @(posedge clk) begin
        int b;
        int side;
        b = int'(byte_dat);
        if (!rst_n) begin
            m_vol = 63; m_sel = 0; m_dout = 3;
            m_att[0] = 31; m_att[1] = 31; m_mute[0] = 1; m_mute[1] = 1;
            m_tone[0] = 1; m_tone[1] = 1;
        end else if (byte_vld) begin
            if (b < 64) m_vol = b;
            else if (b < 96) begin
                m_dout = (b / 8) % 4;
                if ((b / 4) % 2 == 1) m_sel = b % 4;
            end else if (b < 128) begin
                side = (b >= 112) ? 1 : 0;
                m_tone[side] = tone_of(b % 16);
            end else if (b < 192) begin
                side = (b >= 160) ? 1 : 0;
                m_att[side] = b % 32;
                m_mute[side] = (b % 32 == 31) ? 1 : 0;
            end
        end
        armed = 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int snap();
        return int'({vol_att, spk_l_att, spk_l_mute, spk_r_att, spk_r_mute,
                     in_sel, dig_out, bass_lvl, treble_lvl});
    endfunction

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (armed && !done) begin
            chk(int'(vol_att) == m_vol, "R1 vol_att", int'(vol_att), m_vol);
            chk(int'(spk_l_att) == m_att[0], "R2 spk_l_att", int'(spk_l_att), m_att[0]);
            chk(int'(spk_r_att) == m_att[1], "R2 spk_r_att", int'(spk_r_att), m_att[1]);
            chk(int'(spk_l_mute) == m_mute[0], "R3 spk_l_mute", int'(spk_l_mute), m_mute[0]);
            chk(int'(spk_r_mute) == m_mute[1], "R3 spk_r_mute", int'(spk_r_mute), m_mute[1]);
            chk(int'(in_sel) == m_sel, "R5 in_sel", int'(in_sel), m_sel);
            chk(int'(dig_out) == m_dout, "R4 dig_out", int'(dig_out), m_dout);
            chk(int'($signed(bass_lvl)) == m_tone[0], "R6 bass_lvl", int'($signed(bass_lvl)), m_tone[0]);
            chk(int'($signed(treble_lvl)) == m_tone[1], "R6 treble_lvl", int'($signed(treble_lvl)), m_tone[1]);
        end
    end

    // strobe one byte; returns at the falling edge after it took effect
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_dat = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    initial begin
        int s0;
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        // R9: reset values
        chk(vol_att == 6'd63, "R9 vol reset", int'(vol_att), 63);
        chk(spk_l_mute && spk_r_mute, "R9 mute reset", int'({spk_l_mute, spk_r_mute}), 3);
        chk(spk_l_att == 5'd31 && spk_r_att == 5'd31, "R9 spk reset", int'(spk_l_att), 31);
        chk(in_sel == 2'd0, "R9 in_sel reset", int'(in_sel), 0);
        chk(dig_out == 2'b11, "R9 dig_out reset", int'(dig_out), 3);
        chk(bass_lvl == 4'd1 && treble_lvl == 4'd1, "R9 tone reset", int'(bass_lvl), 1);
        rst_n = 1'b1;

        send(8'h24);
        chk(vol_att == 6'd36, "R1 example -45dB", int'(vol_att), 36);
        send(8'hB4);
        chk(spk_r_att == 5'd20 && !spk_r_mute, "R2 example right -25dB", int'(spk_r_att), 20);
        chk(spk_l_mute && spk_l_att == 5'd31, "R2 left untouched", int'(spk_l_att), 31);
        send(8'h9F);
        chk(spk_l_mute, "R3 left mute code", int'(spk_l_mute), 1);
        send(8'h9E);
        chk(!spk_l_mute && spk_l_att == 5'd30, "R3 left max att unmuted", int'(spk_l_att), 30);
        send(8'h62);
        chk($signed(bass_lvl) == -4'sd5, "R6 example bass -10dB", int'($signed(bass_lvl)), -5);
        send(8'h77);
        chk(treble_lvl == 4'd0, "R6 treble 0111 zero", int'(treble_lvl), 0);
        send(8'h7F);
        chk(treble_lvl == 4'd0, "R6 treble 1111 zero", int'(treble_lvl), 0);
        send(8'h78);
        chk(treble_lvl == 4'd7, "R6 treble +14dB", int'(treble_lvl), 7);
        send(8'h56);
        chk(in_sel == 2'd2 && dig_out == 2'b10, "R4 source 3 pins", int'({dig_out, in_sel}), 10);
        send(8'h49);
        chk(in_sel == 2'd2 && dig_out == 2'b01, "R5 source kept", int'({dig_out, in_sel}), 6);

        // R7: reserved prefixes change nothing
        s0 = snap();
        send(8'hC5);
        send(8'hFF);
        chk(snap() == s0, "R7 reserved bytes", snap(), s0);

        // R8: unstrobed data has no effect
        s0 = snap();
        byte_dat = 8'h00;
        repeat (4) @(negedge clk);
        byte_dat = 8'hA0;
        repeat (4) @(negedge clk);
        chk(snap() == s0, "R8 no strobe hold", snap(), s0);

        // full tone table on both registers
        for (int c = 0; c < 16; c++) begin
            send(8'h60 | 8'(c));
            send(8'h70 | 8'(15 - c));
            chk(int'($signed(bass_lvl)) == tone_of(c), "R6 bass table", int'($signed(bass_lvl)), tone_of(c));
        end

        // long mixed stream, checked against the model each clock
        lfsr = 8'h5A;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            byte_dat = lfsr ^ 8'(i);
            byte_vld = (i % 5 != 0);
        end
        @(negedge clk);
        byte_vld = 1'b0;

        // reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk(vol_att == 6'd63 && dig_out == 2'b11, "R9 reset again", int'(vol_att), 63);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule